// File: doc/BRIEF.md
# In-Band Reconfigurable Stream Stage

This block is one stage in a chain of processing stages. Its input is a stream of packet words, and each word carries a 4-bit control code and 16 data bits. A stream opens with a header word that names a target stage. If the stream targets this stage, the stage either takes a new configuration from the stream or runs the stream's data words through its small configurable operator. If the stream targets another stage, the words pass through untouched. The stage sends exactly one word downstream on every clock. Any cycle with no useful result carries a placeholder code, so the stage never stalls the chain.

A configuration stream ends with a tail word. The tail commits the staged configuration, and the stage then spends a fixed reload window of `RECONF_CYCLES` cycles in a reloading state. During that window a static front section stores any arriving words in a small FIFO and sends reload-marker words downstream. Once the window closes, the stored words are parsed in arrival order ahead of newer input. If the FIFO fills, further words are discarded and a sticky flag is raised.

Top module: `sr_stage`

## Requirements
- R1: The output word is registered and changes on every clock. After reset the output code is 0 with data 0, the overflow flag is 0 and the loaded operation is "add 0".
- R2: The control codes are 0 invalid, 1 header, 2 config, 3 data, 4 tail and 5 reload-marker. An input word whose code is 0, 5 or 6..15 is a bubble, and it produces an output word with code 0 and data 0.
- R3: When a header arrives with the stage at rest and its data bits [3:0] differ from `MODULE_ID` (default 3), the stage forwards that header and every later non-bubble word unchanged, one cycle later, up to and including the tail. It then returns to rest.
- R4: A header whose bits [3:0] equal `MODULE_ID` is consumed and produces code 0. If the next non-bubble word is a config word, the stage enters programming. If it is a data word, the stage enters processing and that word is processed. At rest, any word other than a header produces code 0.
- R5: In programming, each config word is consumed (output code 0) and overwrites the staged configuration. The tail commits the last staged value. Config bit 15 selects the operation: 0 adds bits [14:0] zero-extended, and 1 shifts left by bits [3:0].
- R6: For exactly `RECONF_CYCLES` cycles (default 10) after the committing tail, the output is code 5 with data 0, and the input is not parsed. Non-bubble input words are stored instead.
- R7: Stored words are parsed one per cycle, oldest first. While the store is not empty, new non-bubble input is appended behind the stored words.
- R8: The store holds `FIFO_DEPTH` words (default 8). A word that arrives while the store is full and not being read is dropped, and the overflow flag is set. The flag stays set until reset.
- R9: In processing, each data word leaves one cycle later as a data word that holds the loaded operation's result. Addition wraps modulo 2^16.
- R10: In processing, a tail is consumed (output code 0) and returns the stage to rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inCtl | input | 4 | Control code of the incoming word |
| inData | input | 16 | Data bits of the incoming word |
| outCtl | output | 4 | Control code of the outgoing word |
| outData | output | 16 | Data bits of the outgoing word |
| overflow | output | 1 | Sticky flag, set when a word is dropped at the store |

## Verification
The routing decision is exercised with headers that name a different stage and headers that name this stage. The header data carries extra upper bits, which shows that only the low identifier bits are compared. Bubbles and unknown codes are placed in the middle of streams to show they never leak through. Operator tests use the reset identity, an add that wraps, a shift by the maximum amount, and a pair of config words in one stream, which shows that the last one wins. Words sent during the reload window are then used for two things. A short burst, with fresh input arriving behind it, shows that ordering is kept. A burst longer than the store shows exactly which word is the first to be dropped.

// File: rtl/sr_pkg.sv
package sr_pkg;

  localparam int CTL_W = 4;

  typedef enum logic [CTL_W-1:0] {
    CTL_INVALID = 4'h0,
    CTL_HEADER  = 4'h1,
    CTL_CONFIG  = 4'h2,
    CTL_DATA    = 4'h3,
    CTL_TAIL    = 4'h4,
    CTL_IDLE    = 4'h5
  } ctl_e;

  typedef enum logic [2:0] {
    ST_REST,
    ST_ARMED,
    ST_PROGRAM,
    ST_BUSY,
    ST_PASS,
    ST_IDLE
  } state_e;

  typedef enum logic [1:0] {
    OS_INVALID,
    OS_IDLE,
    OS_FWD,
    OS_XFORM
  } outsel_e;

  typedef struct packed {
    logic    push;
    logic    pop;
    logic    cfgWrite;
    logic    cfgCommit;
    outsel_e outSel;
  } strobe_t;

  function automatic logic isWord(logic [CTL_W-1:0] c);
    return (c >= 4'h1) && (c <= 4'h4);
  endfunction

endpackage

// File: rtl/sr_fifo.sv
module sr_fifo #(
  parameter int W     = 20,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wrWord,
  output logic [W-1:0] headWord,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] count;
  logic          doPush, doPop;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign doPop    = pop && !empty;
  assign doPush   = push && (!full || doPop);
  assign headWord = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty); // R7
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH)); // R8

endmodule

// File: rtl/sr_datapath.sv
module sr_datapath
  import sr_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTL_W-1:0]  inCtl,
  input  logic [DATA_W-1:0] inData,
  input  strobe_t           strobe,
  output logic [CTL_W-1:0]  curCtl,
  output logic [DATA_W-1:0] curData,
  output logic              fifoEmpty,
  output logic [CTL_W-1:0]  outCtl,
  output logic [DATA_W-1:0] outData,
  output logic              overflow
);
  localparam int WORD_W = CTL_W + DATA_W;
  localparam int SH_W   = $clog2(DATA_W);

  logic [WORD_W-1:0] headWord;
  logic              fifoFull;

  sr_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strobe.push),
    .pop      (strobe.pop),
    .wrWord   ({inCtl, inData}),
    .headWord (headWord),
    .empty    (fifoEmpty),
    .full     (fifoFull)
  );

  assign curCtl  = fifoEmpty ? inCtl  : headWord[WORD_W-1 -: CTL_W];
  assign curData = fifoEmpty ? inData : headWord[DATA_W-1:0];

  // Configuration: staged while programming, made active at the tail
  logic              stageOp, actOp;
  logic [DATA_W-2:0] stageArg, actArg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageOp  <= 1'b0;
      stageArg <= '0;
      actOp    <= 1'b0;
      actArg   <= '0;
    end else begin
      if (strobe.cfgWrite) begin
        stageOp  <= curData[DATA_W-1];
        stageArg <= curData[DATA_W-2:0];
      end
      if (strobe.cfgCommit) begin
        actOp  <= stageOp;
        actArg <= stageArg;
      end
    end
  end

  // Logarithmic left shifter, one stage per shift-amount bit
  logic [DATA_W-1:0] shStage [SH_W+1];
  assign shStage[0] = curData;
  for (genvar i = 0; i < SH_W; i++) begin : g_shift
    assign shStage[i+1] = actArg[i] ? (shStage[i] << (1 << i)) : shStage[i];
  end

  logic [DATA_W-1:0] addRes, xformRes;
  assign addRes   = curData + {1'b0, actArg};
  assign xformRes = actOp ? shStage[SH_W] : addRes;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outCtl  <= CTL_INVALID;
      outData <= '0;
    end else begin
      case (strobe.outSel)
        OS_IDLE: begin
          outCtl  <= CTL_IDLE;
          outData <= '0;
        end
        OS_FWD: begin
          outCtl  <= curCtl;
          outData <= curData;
        end
        OS_XFORM: begin
          outCtl  <= CTL_DATA;
          outData <= xformRes;
        end
        default: begin
          outCtl  <= CTL_INVALID;
          outData <= '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) overflow <= 1'b0;
    else if (strobe.push && fifoFull && !strobe.pop) overflow <= 1'b1;
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow); // R8
  AST_OUT_CODE: assert property (@(posedge clk) disable iff (!rstN)
    outCtl <= 4'h5); // R2

endmodule

// File: rtl/sr_control.sv
module sr_control
  import sr_pkg::*;
#(
  parameter int          ID_W          = 4,
  parameter logic [3:0]  MODULE_ID     = 4'h3,
  parameter int          RECONF_CYCLES = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CTL_W-1:0] inCtl,
  input  logic [CTL_W-1:0] curCtl,
  input  logic [ID_W-1:0]  curId,
  input  logic             fifoEmpty,
  output strobe_t          strobe,
  output state_e           stateQ
);
  localparam int CNT_W = $clog2(RECONF_CYCLES + 1);

  state_e           stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic             stall, curValid;
  logic             isHdr, isCfg, isDat, isTail, ownId;

  assign stall    = (stateQ == ST_IDLE);
  assign curValid = !stall && isWord(curCtl);
  assign isHdr    = curValid && (curCtl == CTL_HEADER);
  assign isCfg    = curValid && (curCtl == CTL_CONFIG);
  assign isDat    = curValid && (curCtl == CTL_DATA);
  assign isTail   = curValid && (curCtl == CTL_TAIL);
  assign ownId    = (curId == ID_W'(MODULE_ID));

  always_comb begin
    stateD           = stateQ;
    cntD             = cntQ;
    strobe.push      = isWord(inCtl) && (stall || !fifoEmpty);
    strobe.pop       = !stall && !fifoEmpty;
    strobe.cfgWrite  = 1'b0;
    strobe.cfgCommit = 1'b0;
    strobe.outSel    = OS_INVALID;
    case (stateQ)
      ST_REST: begin
        if (isHdr) begin
          if (ownId) stateD = ST_ARMED;
          else begin
            stateD        = ST_PASS;
            strobe.outSel = OS_FWD;
          end
        end
      end
      ST_ARMED: begin
        if (isCfg) begin
          stateD          = ST_PROGRAM;
          strobe.cfgWrite = 1'b1;
        end else if (isDat) begin
          stateD        = ST_BUSY;
          strobe.outSel = OS_XFORM;
        end else if (curValid) begin
          stateD = ST_REST;
        end
      end
      ST_PROGRAM: begin
        if (isCfg) strobe.cfgWrite = 1'b1;
        else if (isTail) begin
          stateD           = ST_IDLE;
          strobe.cfgCommit = 1'b1;
          cntD             = CNT_W'(RECONF_CYCLES - 1);
        end
      end
      ST_BUSY: begin
        if (isDat) strobe.outSel = OS_XFORM;
        else if (isTail) stateD = ST_REST;
      end
      ST_PASS: begin
        if (curValid) strobe.outSel = OS_FWD;
        if (isTail) stateD = ST_REST;
      end
      ST_IDLE: begin
        strobe.outSel = OS_IDLE;
        if (cntQ == '0) stateD = ST_REST;
        else cntD = cntQ - 1'b1;
      end
      default: stateD = ST_REST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_REST;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
    end
  end

  AST_IDLE_NO_POP: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE) |-> !strobe.cfgWrite && (strobe.outSel == OS_IDLE)); // R6
  AST_IDLE_CNT: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE) |-> (cntQ < CNT_W'(RECONF_CYCLES))); // R6

endmodule

// File: rtl/sr_stage.sv
module sr_stage
  import sr_pkg::*;
#(
  parameter int         DATA_W        = 16,
  parameter int         ID_W          = 4,
  parameter logic [3:0] MODULE_ID     = 4'h3,
  parameter int         FIFO_DEPTH    = 8,
  parameter int         RECONF_CYCLES = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        inCtl,
  input  logic [DATA_W-1:0] inData,
  output logic [3:0]        outCtl,
  output logic [DATA_W-1:0] outData,
  output logic              overflow
);
  strobe_t           strobe;
  state_e            stateQ;
  logic [CTL_W-1:0]  curCtl;
  logic [DATA_W-1:0] curData;
  logic              fifoEmpty;

  sr_control #(
    .ID_W          (ID_W),
    .MODULE_ID     (MODULE_ID),
    .RECONF_CYCLES (RECONF_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inCtl     (inCtl),
    .curCtl    (curCtl),
    .curId     (curData[ID_W-1:0]),
    .fifoEmpty (fifoEmpty),
    .strobe    (strobe),
    .stateQ    (stateQ)
  );

  sr_datapath #(
    .DATA_W     (DATA_W),
    .FIFO_DEPTH (FIFO_DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .inCtl     (inCtl),
    .inData    (inData),
    .strobe    (strobe),
    .curCtl    (curCtl),
    .curData   (curData),
    .fifoEmpty (fifoEmpty),
    .outCtl    (outCtl),
    .outData   (outData),
    .overflow  (overflow)
  );

  AST_IDLE_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE) |=> (outCtl == 4'h5) && (outData == '0)); // R6
  AST_PASS_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_PASS) |=> (outCtl != 4'h5)); // R3

endmodule

// File: tb/sr_stage_tb.sv
module sr_stage_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  inCtl = 4'h0;
  logic [15:0] inData = 16'h0;
  logic [3:0]  outCtl;
  logic [15:0] outData;
  logic        overflow;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  localparam int RC = 10;

  always #10 clk = ~clk;

  sr_stage u_dut (
    .clk(clk), .rstN(rstN), .inCtl(inCtl), .inData(inData),
    .outCtl(outCtl), .outData(outData), .overflow(overflow)
  );

  // {inCtl, inData, expCtl, expData}; default config is add 0, own ID 3
  localparam int NV = 14;
  localparam logic [39:0] VEC [NV] = '{
    {4'h0, 16'h0000, 4'h0, 16'h0000},  // R2 bubble
    {4'h9, 16'h1111, 4'h0, 16'h0000},  // R2 unknown code
    {4'h3, 16'h4444, 4'h0, 16'h0000},  // R4 stray data at rest
    {4'h1, 16'h0005, 4'h1, 16'h0005},  // R3 foreign header forwarded
    {4'h3, 16'h1234, 4'h3, 16'h1234},  // R3
    {4'h9, 16'h2222, 4'h0, 16'h0000},  // R2 unknown inside pass stream
    {4'h2, 16'h00FF, 4'h2, 16'h00FF},  // R3 config forwarded unchanged
    {4'h4, 16'h0000, 4'h4, 16'h0000},  // R3 tail forwarded
    {4'h1, 16'h0013, 4'h0, 16'h0000},  // R4 own header, low bits only
    {4'h3, 16'h0010, 4'h3, 16'h0010},  // R9 reset config add 0
    {4'h5, 16'h3333, 4'h0, 16'h0000},  // R2 marker input is bubble
    {4'h3, 16'hFFFF, 4'h3, 16'hFFFF},  // R9
    {4'h4, 16'h0000, 4'h0, 16'h0000},  // R10 tail consumed
    {4'h3, 16'h7777, 4'h0, 16'h0000}   // R10 back at rest
  };

  task automatic step(input logic [3:0] c, input logic [15:0] d,
                      input logic [3:0] ec, input logic [15:0] ed,
                      input string tag);
    @(negedge clk);
    inCtl  = c;
    inData = d;
    @(posedge clk);
    #1;
    checks++;
    if (outCtl !== ec || outData !== ed) begin
      errors++;
      $display("FAIL %s: got ctl %h data %h, expected ctl %h data %h",
               tag, outCtl, outData, ec, ed);
    end
  endtask

  task automatic checkOvf(input logic exp, input string tag);
    checks++;
    if (overflow !== exp) begin
      errors++;
      $display("FAIL %s: overflow got %b expected %b", tag, overflow, exp);
    end
  endtask

  task automatic idleRun(input int n);
    for (int k = 0; k < n; k++) step(4'h0, 16'h0, 4'h5, 16'h0, "R6 reload marker");
  endtask

  task automatic program2(input logic [15:0] cfg);
    step(4'h1, 16'h0003, 4'h0, 16'h0, "R4 own header");
    step(4'h2, cfg,      4'h0, 16'h0, "R5 config consumed");
    step(4'h4, 16'h0000, 4'h0, 16'h0, "R5 tail commits");
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (outCtl !== 4'h0 || outData !== 16'h0) begin
      errors++;
      $display("FAIL R1 reset: got %h/%h expected 0/0", outCtl, outData);
    end
    checkOvf(1'b0, "R1 reset overflow");
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++)
      step(VEC[i][39:36], VEC[i][35:20], VEC[i][19:16], VEC[i][15:0],
           "R2/R3/R4/R9/R10 table");

    // R5/R6/R9: add 5, wrap around
    program2(16'h0005);
    idleRun(RC);
    step(4'h0, 16'h0, 4'h0, 16'h0, "R6 window ends after RECONF_CYCLES");
    step(4'h1, 16'h0003, 4'h0, 16'h0, "R4 own header");
    step(4'h3, 16'h0010, 4'h3, 16'h0015, "R9 add");
    step(4'h3, 16'hFFFE, 4'h3, 16'h0003, "R9 add wraps");
    step(4'h4, 16'h0000, 4'h0, 16'h0, "R10 tail");

    // R5: two config words, last wins; shift by 15
    step(4'h1, 16'h0003, 4'h0, 16'h0, "R4 own header");
    step(4'h2, 16'h0007, 4'h0, 16'h0, "R5 first config");
    step(4'h2, 16'h8004, 4'h0, 16'h0, "R5 second config");
    step(4'h4, 16'h0000, 4'h0, 16'h0, "R5 tail");
    idleRun(RC);
    step(4'h1, 16'h0003, 4'h0, 16'h0, "R4 own header");
    step(4'h3, 16'h0123, 4'h3, 16'h1230, "R5 last config wins, shift 4");
    step(4'h4, 16'h0000, 4'h0, 16'h0, "R10 tail");
    program2(16'h800F);
    idleRun(RC);
    step(4'h1, 16'h0003, 4'h0, 16'h0, "R4 own header");
    step(4'h3, 16'h0003, 4'h3, 16'h8000, "R9 shift 15");
    step(4'h4, 16'h0000, 4'h0, 16'h0, "R10 tail");

    // R6/R7: words buffered during reload, drained in order
    program2(16'h0001);
    step(4'h1, 16'h0003, 4'h5, 16'h0, "R6 header buffered");
    step(4'h3, 16'h0001, 4'h5, 16'h0, "R6 data buffered");
    step(4'h3, 16'h0002, 4'h5, 16'h0, "R6 data buffered");
    step(4'h4, 16'h0000, 4'h5, 16'h0, "R6 tail buffered");
    idleRun(RC - 4);
    step(4'h1, 16'h0005, 4'h0, 16'h0, "R7 stored header first");
    step(4'h3, 16'hAAAA, 4'h3, 16'h0002, "R7 stored data");
    step(4'h4, 16'h0000, 4'h3, 16'h0003, "R7 stored data");
    step(4'h0, 16'h0000, 4'h0, 16'h0, "R7 stored tail");
    step(4'h0, 16'h0000, 4'h1, 16'h0005, "R7 newer input after store");
    step(4'h0, 16'h0000, 4'h3, 16'hAAAA, "R7 newer data");
    step(4'h0, 16'h0000, 4'h4, 16'h0000, "R7 newer tail");
    checkOvf(1'b0, "R8 no drop yet");

    // R8: overflow
    program2(16'h0000);
    step(4'h1, 16'h0003, 4'h5, 16'h0, "R6 buffered");
    for (int k = 1; k <= 8; k++) step(4'h3, 16'(k), 4'h5, 16'h0, "R6 buffered");
    step(4'h4, 16'h0000, 4'h5, 16'h0, "R6 buffered");
    checkOvf(1'b1, "R8 overflow raised");
    step(4'h0, 16'h0000, 4'h0, 16'h0, "R8 stored header");
    for (int k = 1; k <= 7; k++) step(4'h0, 16'h0, 4'h3, 16'(k), "R8 first 8 kept");
    step(4'h0, 16'h0000, 4'h0, 16'h0, "R8 later words dropped");
    step(4'h4, 16'h0000, 4'h0, 16'h0, "R10 tail");
    step(4'h1, 16'h0009, 4'h1, 16'h0009, "R3 at rest after drop");
    step(4'h4, 16'h0000, 4'h4, 16'h0000, "R3 tail");
    checkOvf(1'b1, "R8 sticky");

    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    #1;
    checkOvf(1'b0, "R8 cleared by reset");
    @(negedge clk);
    rstN = 1'b1;
    step(4'h1, 16'h0003, 4'h0, 16'h0, "R1 own header");
    step(4'h3, 16'h0042, 4'h3, 16'h0042, "R1 reset restores add 0");

    done = 1'b1;
    finishRun();
  end
endmodule